// File: doc/BRIEF.md
# Microcoded Fetch-Decode-Execute Sequencer

This block is the control core of a small word-addressed processor. A microcode address register (the micro-PC) selects one control word from a computed control store. The control word steers the address and data buses, the register loads and the choice of the next micro-PC. Every instruction goes through the same cycle. A fetch state reads the word at the instruction pointer into the instruction register. A decode state then jumps through a 16-entry table indexed by the top four instruction bits. One or more execute states follow, and the last of them returns to fetch.

Memory is reached through a request/acknowledge handshake. Any state that issues a request stalls in place until the acknowledge arrives, so the same control word serves any memory latency. The instruction set is deliberately small: no operation, jump, load constant, load, store and load indirect. All other opcodes end in a trap state that flags an illegal instruction and resumes fetching. Arithmetic is outside this block.

Top module: `useq_core`

## Requirements
- R1: While `rst_n` is sampled low, the micro-PC goes to 0x000, the instruction pointer to `BOOT_ADDR` (default 0x0010) and the accumulator to 0.
- R2: At micro-PC 0x000 (fetch), `mem_req`=1, `mem_we`=0 and `mem_addr` equals the instruction pointer. The micro-PC stays at 0x000 for every cycle in which `mem_ack` is low.
- R3: In a fetch cycle with `mem_ack` high, the instruction register takes `mem_rdata`, the instruction pointer increments by one and the micro-PC becomes 0x001 (decode) at the next edge.
- R4: Decode lasts one cycle. The next micro-PC comes from the opcode in instruction bits [31:28]: 0 no-op→0x010, 1 jump→0x020, 2 load constant→0x030, 3 load→0x040, 4 store→0x050, 5 load indirect→0x060. The operand is bits [27:0], and its low `ADDR_W` bits serve as the memory or jump address.
- R5: The no-op, jump and load-constant states last one cycle and then return to 0x000. The no-op changes nothing. The jump loads the instruction pointer with the operand address. The load constant puts the zero-extended operand in the accumulator.
- R6: At 0x040 the block reads the operand address (`mem_req`=1, `mem_we`=0), waits for `mem_ack`, loads `mem_rdata` into the accumulator and returns to 0x000.
- R7: At 0x050 the block writes the accumulator to the operand address (`mem_req`=1, `mem_we`=1, `mem_wdata` = accumulator), waits for `mem_ack` and returns to 0x000. `mem_we` is never high in any other state.
- R8: The load indirect chains two states. At 0x060 it reads the operand address into a pointer and moves to 0x061 on `mem_ack`. At 0x061 it reads the address held in the pointer into the accumulator and returns to 0x000 on `mem_ack`.
- R9: Opcodes 6 to 15 dispatch to trap state 0x0F0. The trap raises `illegal_o` for exactly that one cycle, returns to 0x000 and leaves the accumulator and instruction pointer unchanged.
- R10: The instruction pointer changes only on a fetch acknowledge or in the jump state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| mem_req | output | 1 | Memory request, held until acknowledged |
| mem_we | output | 1 | Write strobe qualifying `mem_req` |
| mem_addr | output | ADDR_W (16) | Word address |
| mem_wdata | output | DATA_W (32) | Write data |
| mem_rdata | input | DATA_W (32) | Read data, valid with `mem_ack` |
| mem_ack | input | 1 | Completes the pending request this cycle |
| illegal_o | output | 1 | High during the trap state |
| upc_o | output | 10 | Current micro-PC |
| ip_o | output | ADDR_W (16) | Instruction pointer |
| acc_o | output | DATA_W (32) | Accumulator |

## Verification
The bench memory model raises `mem_ack` L+1 edges after it first samples a request, with L set per scenario. Any requesting state (fetch, load, store, both load-indirect states) therefore shows its micro-PC for L+2 falling-edge samples, and the successor address appears at the next sample. Decode and single-cycle execute states last exactly one sample each. A captured accumulator or instruction pointer value is visible at the same falling edge where the micro-PC first shows the successor state. The bench walks each instruction state by state at falling edges, checks the micro-PC and bus outputs at every sample, and checks the register results at the sample where they are due.

// File: rtl/useq_pkg.sv
// Package: shared micro-address map, control-word layout, control store
// contents and dispatch table for the microcoded sequencer.
// Assumes a 4-bit opcode in the top bits of each instruction word.
package useq_pkg;

    localparam int UA_W = 10;
    typedef logic [UA_W-1:0] uaddr_t;

    // Micro-address map; execute entries sit on 16-word boundaries
    localparam uaddr_t UA_FETCH  = 10'h000;
    localparam uaddr_t UA_DECODE = 10'h001;
    localparam uaddr_t UA_NOP    = 10'h010;
    localparam uaddr_t UA_JMP    = 10'h020;
    localparam uaddr_t UA_LDC    = 10'h030;
    localparam uaddr_t UA_LD     = 10'h040;
    localparam uaddr_t UA_ST     = 10'h050;
    localparam uaddr_t UA_LDX0   = 10'h060;
    localparam uaddr_t UA_LDX1   = 10'h061;
    localparam uaddr_t UA_TRAP   = 10'h0F0;

    // Opcode values
    localparam int unsigned OPC_NOP = 0;
    localparam int unsigned OPC_JMP = 1;
    localparam int unsigned OPC_LDC = 2;
    localparam int unsigned OPC_LD  = 3;
    localparam int unsigned OPC_ST  = 4;
    localparam int unsigned OPC_LDX = 5;

    typedef enum logic [1:0] {SEQ_GOTO, SEQ_DISPATCH, SEQ_WAIT} seq_e;
    typedef enum logic [1:0] {ASEL_IP, ASEL_OPND, ASEL_PTR} asel_e;
    typedef enum logic [1:0] {DSRC_MEM, DSRC_ACC, DSRC_OPND} dsrc_e;
    typedef enum logic [1:0] {DDST_NONE, DDST_IR, DDST_ACC, DDST_PTR} ddst_e;

    typedef struct packed {
        uaddr_t nxt;      // successor for GOTO / WAIT
        seq_e   seq;      // next-address policy
        asel_e  asel;     // address-bus source
        dsrc_e  dsrc;     // data-bus source
        ddst_e  ddst;     // data-bus destination
        logic   req;      // memory request
        logic   we;       // memory write
        logic   ip_inc;   // step IP on completion
        logic   ip_load;  // load IP from operand
        logic   illegal;  // illegal-instruction flag
    } uword_t;

    // Control store contents, computed per micro-address
    function automatic uword_t urom_word(input uaddr_t a);
        uword_t w;
        w      = '0;
        w.nxt  = UA_FETCH;
        w.seq  = SEQ_GOTO;
        w.asel = ASEL_IP;
        w.dsrc = DSRC_MEM;
        w.ddst = DDST_NONE;
        case (a)
            UA_FETCH: begin
                w.nxt = UA_DECODE; w.seq = SEQ_WAIT; w.ddst = DDST_IR;
                w.req = 1'b1; w.ip_inc = 1'b1;
            end
            UA_DECODE: w.seq = SEQ_DISPATCH;
            UA_NOP:    w.seq = SEQ_GOTO;
            UA_JMP:    w.ip_load = 1'b1;
            UA_LDC: begin
                w.dsrc = DSRC_OPND; w.ddst = DDST_ACC;
            end
            UA_LD: begin
                w.seq = SEQ_WAIT; w.asel = ASEL_OPND; w.ddst = DDST_ACC;
                w.req = 1'b1;
            end
            UA_ST: begin
                w.seq = SEQ_WAIT; w.asel = ASEL_OPND; w.dsrc = DSRC_ACC;
                w.req = 1'b1; w.we = 1'b1;
            end
            UA_LDX0: begin
                w.nxt = UA_LDX1; w.seq = SEQ_WAIT; w.asel = ASEL_OPND;
                w.ddst = DDST_PTR; w.req = 1'b1;
            end
            UA_LDX1: begin
                w.seq = SEQ_WAIT; w.asel = ASEL_PTR; w.ddst = DDST_ACC;
                w.req = 1'b1;
            end
            UA_TRAP:   w.illegal = 1'b1;
            default:   w.seq = SEQ_GOTO;
        endcase
        return w;
    endfunction

    // Dispatch target for one opcode value
    function automatic uaddr_t dispatch_entry(input int unsigned code);
        case (code)
            OPC_NOP: return UA_NOP;
            OPC_JMP: return UA_JMP;
            OPC_LDC: return UA_LDC;
            OPC_LD:  return UA_LD;
            OPC_ST:  return UA_ST;
            OPC_LDX: return UA_LDX0;
            default: return UA_TRAP;
        endcase
    endfunction

endpackage

// File: rtl/useq_urom.sv
// Module: control store. Maps the micro-PC to its control word.
// Assumes: purely combinational, contents defined in useq_pkg.
module useq_urom
    import useq_pkg::*;
(
    input  uaddr_t upc,
    output uword_t uw
);

    // Look up the control word for the current micro-address
    always_comb begin
        uw = urom_word(upc);
    end

endmodule

// File: rtl/useq_dispatch.sv
// Module: opcode dispatch table, one entry per opcode value.
// Assumes: OPC_W-bit opcode; entries computed from useq_pkg.
module useq_dispatch
    import useq_pkg::*;
#(
    parameter int OPC_W = 4
) (
    input  logic [OPC_W-1:0] opc,
    output uaddr_t           target
);

    localparam int N_ENT = 1 << OPC_W;

    uaddr_t tbl [N_ENT];

    // One table entry per opcode value
    for (genvar g = 0; g < N_ENT; g++) begin : g_ent
        assign tbl[g] = dispatch_entry(g);
    end

    // Select the entry for the decoded opcode
    assign target = tbl[opc];

endmodule

// File: rtl/useq_upc.sv
// Module: micro-PC register and next-address selection.
// Assumes: WAIT states hold until mem_ack; reset is synchronous.
module useq_upc
    import useq_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  seq_e   seq,
    input  uaddr_t nxt,
    input  uaddr_t disp,
    input  logic   mem_ack,
    output uaddr_t upc
);

    uaddr_t upc_nxt;

    // Choose the next micro-address from the sequencing policy
    always_comb begin
        case (seq)
            SEQ_GOTO:     upc_nxt = nxt;
            SEQ_DISPATCH: upc_nxt = disp;
            SEQ_WAIT:     upc_nxt = mem_ack ? nxt : upc;
            default:      upc_nxt = UA_FETCH;
        endcase
    end

    // Micro-PC register, reset to the fetch entry
    always_ff @(posedge clk) begin
        if (!rst_n) upc <= UA_FETCH;
        else        upc <= upc_nxt;
    end

endmodule

// File: rtl/useq_datapath.sv
// Module: instruction pointer, instruction register, pointer and
// accumulator, with the address and data bus multiplexers.
// Assumes: ADDR_W <= DATA_W-4; a requested transfer commits on mem_ack,
// an unrequested one commits in its single cycle.
module useq_datapath
    import useq_pkg::*;
#(
    parameter int                ADDR_W    = 16,
    parameter int                DATA_W    = 32,
    parameter int                OPC_W     = 4,
    parameter logic [ADDR_W-1:0] BOOT_ADDR = 16'h0010
) (
    input  logic              clk,
    input  logic              rst_n,
    input  asel_e             asel,
    input  dsrc_e             dsrc,
    input  ddst_e             ddst,
    input  logic              req,
    input  logic              ip_inc,
    input  logic              ip_load,
    input  logic              mem_ack,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic [ADDR_W-1:0] abus,
    output logic [DATA_W-1:0] dbus,
    output logic [OPC_W-1:0]  opc,
    output logic [ADDR_W-1:0] ip,
    output logic [DATA_W-1:0] acc
);

    localparam int OPND_W = DATA_W - OPC_W;

    logic [DATA_W-1:0] ir;
    logic [ADDR_W-1:0] ptr;
    logic              commit;

    // Transfer completes on acknowledge, or at once if nothing requested
    assign commit = req ? mem_ack : 1'b1;

    // Address bus source
    always_comb begin
        case (asel)
            ASEL_IP:   abus = ip;
            ASEL_OPND: abus = ir[ADDR_W-1:0];
            ASEL_PTR:  abus = ptr;
            default:   abus = ip;
        endcase
    end

    // Data bus source
    always_comb begin
        case (dsrc)
            DSRC_MEM:  dbus = mem_rdata;
            DSRC_ACC:  dbus = acc;
            DSRC_OPND: dbus = {{OPC_W{1'b0}}, ir[OPND_W-1:0]};
            default:   dbus = mem_rdata;
        endcase
    end

    // Instruction register, loaded from the data bus in fetch
    always_ff @(posedge clk) begin
        if (!rst_n)                        ir <= '0;
        else if (ddst == DDST_IR && commit) ir <= dbus;
    end

    // Indirection pointer for the two-step load
    always_ff @(posedge clk) begin
        if (!rst_n)                         ptr <= '0;
        else if (ddst == DDST_PTR && commit) ptr <= dbus[ADDR_W-1:0];
    end

    // Accumulator
    always_ff @(posedge clk) begin
        if (!rst_n)                         acc <= '0;
        else if (ddst == DDST_ACC && commit) acc <= dbus;
    end

    // Instruction pointer: jump load or post-fetch increment
    always_ff @(posedge clk) begin
        if (!rst_n)                 ip <= BOOT_ADDR;
        else if (ip_load)           ip <= ir[ADDR_W-1:0];
        else if (ip_inc && commit)  ip <= ip + 1'b1;
    end

    // Opcode field for the dispatch table
    assign opc = ir[DATA_W-1 -: OPC_W];

endmodule

// File: rtl/useq_core.sv
// Module: microcoded fetch-decode-execute sequencer (top).
// Assumes: single-word instructions, 4-bit opcode in the top bits,
// memory completes each request by raising mem_ack for one cycle.
module useq_core
    import useq_pkg::*;
#(
    parameter int                ADDR_W    = 16,
    parameter int                DATA_W    = 32,
    parameter logic [ADDR_W-1:0] BOOT_ADDR = 16'h0010
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    input  logic              mem_ack,
    output logic              illegal_o,
    output logic [UA_W-1:0]   upc_o,
    output logic [ADDR_W-1:0] ip_o,
    output logic [DATA_W-1:0] acc_o
);

    localparam int OPC_W = 4;

    uaddr_t            upc;
    uaddr_t            disp;
    uword_t            uw;
    logic [OPC_W-1:0]  opc;

    useq_urom u_urom (
        .upc (upc),
        .uw  (uw)
    );

    useq_dispatch #(.OPC_W(OPC_W)) u_disp (
        .opc    (opc),
        .target (disp)
    );

    useq_upc u_upc (
        .clk     (clk),
        .rst_n   (rst_n),
        .seq     (uw.seq),
        .nxt     (uw.nxt),
        .disp    (disp),
        .mem_ack (mem_ack),
        .upc     (upc)
    );

    useq_datapath #(
        .ADDR_W    (ADDR_W),
        .DATA_W    (DATA_W),
        .OPC_W     (OPC_W),
        .BOOT_ADDR (BOOT_ADDR)
    ) u_dp (
        .clk       (clk),
        .rst_n     (rst_n),
        .asel      (uw.asel),
        .dsrc      (uw.dsrc),
        .ddst      (uw.ddst),
        .req       (uw.req),
        .ip_inc    (uw.ip_inc),
        .ip_load   (uw.ip_load),
        .mem_ack   (mem_ack),
        .mem_rdata (mem_rdata),
        .abus      (mem_addr),
        .dbus      (mem_wdata),
        .opc       (opc),
        .ip        (ip_o),
        .acc       (acc_o)
    );

    // Control strobes straight from the control word
    assign mem_req   = uw.req;
    assign mem_we    = uw.we;
    assign illegal_o = uw.illegal;
    assign upc_o     = upc;

endmodule

// File: rtl/useq_core_chk.sv
// Module: property checker for useq_core, attached by bind.
// Assumes: observes only the top-level ports.
module useq_core_chk
    import useq_pkg::*;
#(
    parameter int                ADDR_W    = 16,
    parameter int                DATA_W    = 32,
    parameter logic [ADDR_W-1:0] BOOT_ADDR = 16'h0010
) (
    input logic              clk,
    input logic              rst_n,
    input uaddr_t            upc,
    input logic [ADDR_W-1:0] ip,
    input logic [DATA_W-1:0] acc,
    input logic              mem_req,
    input logic              mem_we,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              mem_ack,
    input logic              illegal
);

    logic was_rst = 1'b0;

    // Reset state check one edge after reset was sampled
    always_ff @(posedge clk) begin
        was_rst <= !rst_n;
        if (was_rst && rst_n) begin
            assert_reset_state_R1: assert (upc == UA_FETCH && ip == BOOT_ADDR && acc == '0)
                else $error("reset state wrong");
        end
    end

    assert_fetch_bus_R2: assert property (@(posedge clk) disable iff (!rst_n)
        upc == UA_FETCH |-> (mem_req && !mem_we && mem_addr == ip));

    assert_fetch_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (upc == UA_FETCH && !mem_ack) |=> upc == UA_FETCH);

    assert_fetch_advance_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (upc == UA_FETCH && mem_ack) |=> (upc == UA_DECODE && ip == ADDR_W'($past(ip) + 1'b1)));

    assert_decode_dispatch_R4: assert property (@(posedge clk) disable iff (!rst_n)
        upc == UA_DECODE |=> (upc[3:0] == 4'h0 && upc != UA_FETCH));

    assert_single_return_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (upc == UA_NOP || upc == UA_JMP || upc == UA_LDC) |=> upc == UA_FETCH);

    assert_load_return_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (upc == UA_LD && mem_ack) |=> upc == UA_FETCH);

    assert_write_only_store_R7: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> (upc == UA_ST && mem_req));

    assert_indirect_chain_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (upc == UA_LDX0 && mem_ack) |=> upc == UA_LDX1);

    assert_trap_flag_R9: assert property (@(posedge clk) disable iff (!rst_n)
        illegal |-> upc == UA_TRAP);

    assert_trap_return_R9: assert property (@(posedge clk) disable iff (!rst_n)
        upc == UA_TRAP |=> (upc == UA_FETCH && !illegal && $stable(acc)));

    assert_ip_stable_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (upc != UA_FETCH && upc != UA_JMP) |=> $stable(ip));

endmodule

bind useq_core useq_core_chk #(
    .ADDR_W    (ADDR_W),
    .DATA_W    (DATA_W),
    .BOOT_ADDR (BOOT_ADDR)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .upc      (upc_o),
    .ip       (ip_o),
    .acc      (acc_o),
    .mem_req  (mem_req),
    .mem_we   (mem_we),
    .mem_addr (mem_addr),
    .mem_ack  (mem_ack),
    .illegal  (illegal_o)
);

// File: tb/useq_core_tb_top.sv
`timescale 1ns/1ps
// Bench: directed scenarios, one task each, against a latency-programmable
// memory model. All sampling at the falling clock edge.
module useq_core_tb_top;

    localparam logic [9:0] S_FETCH = 10'h000, S_DEC = 10'h001, S_NOP = 10'h010,
                           S_JMP = 10'h020, S_LDC = 10'h030, S_LD = 10'h040,
                           S_ST = 10'h050, S_LDX0 = 10'h060, S_LDX1 = 10'h061,
                           S_TRAP = 10'h0F0;
    localparam logic [15:0] BOOT = 16'h0010;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mem_req, mem_we, mem_ack, illegal_o;
    logic [15:0] mem_addr, ip_o;
    logic [31:0] mem_wdata, mem_rdata, acc_o;
    logic [9:0]  upc_o;

    int n_chk = 0;
    int n_err = 0;
    int lat   = 0;
    bit done  = 1'b0;

    // memory model state
    logic [31:0] mem [256];
    int          cnt;
    logic        pl_we = 1'b0;
    logic [7:0]  pl_addr = '0;
    logic [31:0] pl_data = '0;

    always #10 clk = ~clk;

    useq_core dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .mem_req   (mem_req),
        .mem_we    (mem_we),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .mem_rdata (mem_rdata),
        .mem_ack   (mem_ack),
        .illegal_o (illegal_o),
        .upc_o     (upc_o),
        .ip_o      (ip_o),
        .acc_o     (acc_o)
    );

    // Memory: ack lat+1 edges after a request is first sampled
    always @(posedge clk) begin
        if (pl_we) mem[pl_addr] <= pl_data;
        if (!rst_n) begin
            mem_ack <= 1'b0; cnt <= 0; mem_rdata <= '0;
        end else if (mem_ack) begin
            mem_ack <= 1'b0; cnt <= 0;
        end else if (mem_req) begin
            if (cnt == lat) begin
                mem_ack   <= 1'b1;
                cnt       <= 0;
                mem_rdata <= mem[mem_addr[7:0]];
                if (mem_we) mem[mem_addr[7:0]] <= mem_wdata;
            end else begin
                cnt <= cnt + 1;
            end
        end else begin
            cnt <= 0;
        end
    end

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic poke(input logic [7:0] a, input logic [31:0] d);
        pl_we = 1'b1; pl_addr = a; pl_data = d;
        @(negedge clk);
        pl_we = 1'b0;
    endtask

    task automatic enter_reset(input int l);
        @(negedge clk);
        rst_n = 1'b0;
        lat   = l;
        repeat (2) @(negedge clk);
    endtask

    task automatic leave_reset;
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic fetch_phase(input logic [15:0] exp_ip);
        chk("R2", "fetch upc", upc_o, S_FETCH);
        chk("R2", "fetch req", mem_req, 1);
        chk("R2", "fetch we", mem_we, 0);
        chk("R2", "fetch addr", mem_addr, exp_ip);
        for (int i = 0; i <= lat; i++) begin
            @(negedge clk);
            chk("R2", "fetch hold", upc_o, S_FETCH);
        end
        @(negedge clk);
        chk("R3", "to decode", upc_o, S_DEC);
        chk("R3", "ip step", ip_o, exp_ip + 16'd1);
    endtask

    task automatic decode_phase(input logic [9:0] exp);
        @(negedge clk);
        chk("R4", "dispatch", upc_o, exp);
    endtask

    task automatic mem_phase(input string req, input logic [9:0] st, input logic [9:0] nxt,
                             input logic [15:0] addr, input logic we);
        chk(req, "state", upc_o, st);
        chk(req, "req", mem_req, 1);
        chk(req, "we", mem_we, we);
        chk(req, "addr", mem_addr, addr);
        for (int i = 0; i <= lat; i++) begin
            @(negedge clk);
            chk(req, "wait hold", upc_o, st);
        end
        @(negedge clk);
        chk(req, "successor", upc_o, nxt);
    endtask

    task automatic single_phase(input string req);
        @(negedge clk);
        chk(req, "back to fetch", upc_o, S_FETCH);
    endtask

    // Shared prologue: word at BOOT jumps to the scenario start
    task automatic boot_to(input logic [15:0] start);
        leave_reset;
        fetch_phase(BOOT);
        decode_phase(S_JMP);
        single_phase("R5");
        chk("R5", "jump target", ip_o, start);
    endtask

    task automatic t_reset;
        enter_reset(0);
        chk("R1", "upc", upc_o, S_FETCH);
        chk("R1", "ip", ip_o, BOOT);
        chk("R1", "acc", acc_o, 0);
        chk("R1", "illegal", illegal_o, 0);
        chk("R1", "addr", mem_addr, BOOT);
    endtask

    task automatic t_fetch_nop;
        enter_reset(3);
        poke(8'h10, 32'h1000_0020);
        poke(8'h20, 32'h0000_0000);
        boot_to(16'h0020);
        fetch_phase(16'h0020);
        decode_phase(S_NOP);
        chk("R5", "nop illegal", illegal_o, 0);
        single_phase("R5");
        chk("R5", "nop acc", acc_o, 0);
        chk("R10", "nop ip", ip_o, 16'h0021);
    endtask

    task automatic t_ldc_st;
        enter_reset(1);
        poke(8'h10, 32'h1000_0030);
        poke(8'h30, 32'h2A0A_BCDE);
        poke(8'h31, 32'h4000_0090);
        poke(8'h90, 32'h0);
        boot_to(16'h0030);
        fetch_phase(16'h0030);
        decode_phase(S_LDC);
        single_phase("R5");
        chk("R5", "ldc acc", acc_o, 32'h0A0A_BCDE);
        fetch_phase(16'h0031);
        decode_phase(S_ST);
        chk("R7", "wdata", mem_wdata, 32'h0A0A_BCDE);
        mem_phase("R7", S_ST, S_FETCH, 16'h0090, 1'b1);
        chk("R7", "stored word", mem[8'h90], 32'h0A0A_BCDE);
        chk("R7", "we after", mem_we, 0);
        chk("R10", "ip after st", ip_o, 16'h0032);
    endtask

    task automatic t_ld;
        enter_reset(2);
        poke(8'h10, 32'h1000_0038);
        poke(8'h38, 32'h3000_0080);
        poke(8'h80, 32'hDEAD_BEEF);
        boot_to(16'h0038);
        fetch_phase(16'h0038);
        decode_phase(S_LD);
        mem_phase("R6", S_LD, S_FETCH, 16'h0080, 1'b0);
        chk("R6", "load acc", acc_o, 32'hDEAD_BEEF);
        chk("R10", "ip after ld", ip_o, 16'h0039);
    endtask

    task automatic t_ldx;
        enter_reset(0);
        poke(8'h10, 32'h1000_003C);
        poke(8'h3C, 32'h5000_0081);
        poke(8'h81, 32'h0000_0082);
        poke(8'h82, 32'hCAFE_F00D);
        boot_to(16'h003C);
        fetch_phase(16'h003C);
        decode_phase(S_LDX0);
        mem_phase("R8", S_LDX0, S_LDX1, 16'h0081, 1'b0);
        mem_phase("R8", S_LDX1, S_FETCH, 16'h0082, 1'b0);
        chk("R8", "indirect acc", acc_o, 32'hCAFE_F00D);
    endtask

    task automatic t_trap_sweep;
        enter_reset(0);
        poke(8'h10, 32'h1000_0050);
        poke(8'h50, 32'h2000_0055);
        for (int op = 6; op < 16; op++)
            poke(8'h51 + 8'(op - 6), {4'(op), 28'h0000_ABC});
        boot_to(16'h0050);
        fetch_phase(16'h0050);
        decode_phase(S_LDC);
        single_phase("R5");
        for (int op = 6; op < 16; op++) begin
            logic [15:0] a;
            a = 16'h0051 + 16'(op - 6);
            fetch_phase(a);
            decode_phase(S_TRAP);
            chk("R9", $sformatf("illegal op %0d", op), illegal_o, 1);
            chk("R9", "acc kept", acc_o, 32'h55);
            @(negedge clk);
            chk("R9", "trap return", upc_o, S_FETCH);
            chk("R9", "illegal cleared", illegal_o, 0);
            chk("R10", "ip after trap", ip_o, a + 16'd1);
        end
    endtask

    initial begin
        t_reset;
        t_fetch_nop;
        t_ldc_st;
        t_ld;
        t_ldx;
        t_trap_sweep;
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
        $finish;
    end

    // Watchdog: a hung run counts as one failed check
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
            $finish;
        end
    end

endmodule